// File: doc/BRIEF.md
# Reorder Buffer Partition Resizing Controller

This controller decides how many equal-sized partitions of a circular reorder buffer are switched on and available for allocation. Partitions are always enabled from the lowest index upward, so the live allocation is a contiguous region that starts at entry zero. The controller watches the buffer's occupancy count, its head and tail pointers, and a flag that is raised in every cycle where dispatch is held off because the buffer is full.

Shrinking is slow and deliberate. Occupancy is sampled once every `SP` cycles. The samples are summed over an update window of `UP` cycles and divided with a shift. At the end of each window the average is rounded up to whole partitions, with a floor of one. If that target is lower than the current allocation, the allocation drops to the target. The drop happens only when no live entry sits in a partition that would be switched off. Otherwise the shrink waits for a later window.

Growing is fast. A counter of full-buffer stall cycles adds one partition as soon as it passes the threshold `OT`. The counter restarts after each growth step and at the end of every window.

Top module: `rob_part_sizer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `active_o` equals `NPART` and every bit of `part_en_o` is 1.
- R2: Bit p of `part_en_o` is 1 exactly when p < `active_o`, so the enabled partitions are always the lowest ones.
- R3: Occupancy is sampled only in cycles 3, 7, 11 and 15 of each 16-cycle window (every `SP`-th cycle, counted from reset release). The value of `occ_i` in any other cycle has no effect on `active_o`.
- R4: `active_o` can only fall in the cycle after the last cycle of a window. The new value is ceil(avg / `PART_DEPTH`) with a floor of 1, where avg = (sum of the `UP`/`SP` samples) >> log2(`UP`/`SP`).
- R5: When the rounded target is equal to or above the current allocation, the end of a window leaves `active_o` unchanged.
- R6: A shrink to target t goes ahead only if the buffer is empty, or if `tail_i` > `head_i` and `tail_i` <= t*`PART_DEPTH`. When `tail_i` <= `head_i` and occupancy is nonzero, the live region is treated as wrapped and the shrink is deferred.
- R7: The stall counter adds one in each cycle where `full_stall_i` is 1. In the cycle where the count including that cycle exceeds `OT`, `active_o` rises by exactly one on the next edge and the counter returns to zero.
- R8: The stall counter returns to zero after the last cycle of every window, so stalls never carry over from one window into the next.
- R9: `active_o` always stays between 1 and `NPART`. Stalls that happen while the allocation is already `NPART` leave it unchanged.
- R10: If a growth step and a shrink fall due in the same cycle, the growth step wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occ_i | input | $clog2(NPART*PART_DEPTH+1) | Current number of live entries |
| full_stall_i | input | 1 | Dispatch blocked this cycle because the buffer is full |
| head_i | input | $clog2(NPART*PART_DEPTH) | Index of the oldest live entry |
| tail_i | input | $clog2(NPART*PART_DEPTH) | Index one past the youngest live entry |
| active_o | output | $clog2(NPART+1) | Number of enabled partitions |
| part_en_o | output | NPART | Per-partition enable, lowest partitions first |

## Verification
The bench builds the block with four partitions of eight entries each, `SP`=4, `UP`=16 and `OT`=4. With these values a window holds only four samples, so a single scenario is short enough to set the occupancy at sampled and unsampled cycles separately. The small threshold lets five stall cycles trigger a growth step. This brings several cases within reach of short scenarios: a growth step that lands on the last cycle of a window, stalls that straddle a window boundary, and a shrink held back by entries in the top partition or by a wrapped live region.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
    typedef enum logic [1:0] {
        RSZ_HOLD   = 2'd0,
        RSZ_GROW   = 2'd1,
        RSZ_SHRINK = 2'd2
    } rsz_act_e;
endpackage

// File: rtl/rsz_tick.sv
module rsz_tick #(
    parameter int SP = 4,
    parameter int UP = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic sample_o,
    output logic period_end_o
);
    localparam int SP_W = (SP > 1) ? $clog2(SP) : 1;
    localparam int UP_W = (UP > 1) ? $clog2(UP) : 1;

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic [UP_W-1:0] up;
    } tick_t;

    tick_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sp = st_q.sp + SP_W'(1);
        st_d.up = st_q.up + UP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_o     = (st_q.sp == SP_W'(SP - 1));
    assign period_end_o = (st_q.up == UP_W'(UP - 1));

    // R4: the window always closes on a sampling cycle
    p_end_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |-> sample_o);
endmodule

// File: rtl/rsz_occ_avg.sv
module rsz_occ_avg #(
    parameter int CNT_W   = 6,
    parameter int NS      = 4,
    parameter int LOG_PD  = 3,
    parameter int PCNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              period_end_i,
    input  logic [CNT_W-1:0]  occ_i,
    output logic [PCNT_W-1:0] target_o
);
    localparam int LOG_NS = (NS > 1) ? $clog2(NS) : 0;
    localparam int ACC_W  = CNT_W + LOG_NS;
    localparam int PD     = 1 << LOG_PD;

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] sum;
    logic [CNT_W:0]   avg;
    logic [CNT_W:0]   parts;

    always_comb begin
        sum   = acc_q + ACC_W'(occ_i);
        avg   = (CNT_W + 1)'(sum >> LOG_NS);
        parts = (avg + (CNT_W + 1)'(PD - 1)) >> LOG_PD;
        if (parts == '0) target_o = PCNT_W'(1);
        else             target_o = PCNT_W'(parts);
        acc_d = acc_q;
        if (period_end_i)  acc_d = '0;
        else if (sample_i) acc_d = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R3: occupancy outside sampling cycles leaves the sum untouched
    p_acc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> (acc_q == $past(acc_q)));
endmodule

// File: rtl/rsz_part_dec.sv
module rsz_part_dec #(
    parameter int NPART  = 4,
    parameter int PCNT_W = 3
) (
    input  logic [PCNT_W-1:0] active_i,
    output logic [NPART-1:0]  part_en_o
);
    for (genvar p = 0; p < NPART; p++) begin : g_en
        assign part_en_o[p] = (active_i > PCNT_W'(p));
    end

    // R2: number of enabled partitions matches the count
    always_comb begin
        p_thermo_r2: assert ($countones(part_en_o) == int'(active_i));
    end
endmodule

// File: rtl/rob_part_sizer.sv
module rob_part_sizer #(
    parameter int NPART      = 4,
    parameter int PART_DEPTH = 8,
    parameter int SP         = 4,
    parameter int UP         = 16,
    parameter int OT         = 4,
    localparam int DEPTH  = NPART * PART_DEPTH,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int PCNT_W = $clog2(NPART + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  occ_i,
    input  logic              full_stall_i,
    input  logic [PTR_W-1:0]  head_i,
    input  logic [PTR_W-1:0]  tail_i,
    output logic [PCNT_W-1:0] active_o,
    output logic [NPART-1:0]  part_en_o
);
    import rsz_pkg::*;

    localparam int LOG_PD = $clog2(PART_DEPTH);
    localparam int NS     = UP / SP;
    localparam int OVF_W  = $clog2(OT + 3);
    localparam int LIM_W  = PCNT_W + LOG_PD;

    typedef struct packed {
        logic [PCNT_W-1:0] active;
        logic [OVF_W-1:0]  ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              sample, period_end;
    logic [PCNT_W-1:0] target;
    logic [OVF_W-1:0]  ovf_inc;
    logic [LIM_W-1:0]  limit;
    logic              live_clear;
    rsz_act_e          act;

    rsz_tick #(.SP(SP), .UP(UP)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .sample_o(sample), .period_end_o(period_end)
    );

    rsz_occ_avg #(.CNT_W(CNT_W), .NS(NS), .LOG_PD(LOG_PD), .PCNT_W(PCNT_W)) u_avg (
        .clk(clk), .rst_n(rst_n),
        .sample_i(sample), .period_end_i(period_end),
        .occ_i(occ_i), .target_o(target)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ovf_inc    = ctl_q.ovf + OVF_W'(full_stall_i);
        limit      = LIM_W'(target) << LOG_PD;
        live_clear = (occ_i == '0) ||
                     ((tail_i > head_i) && (LIM_W'(tail_i) <= limit));
        act = RSZ_HOLD;
        if ((ovf_inc > OVF_W'(OT)) && (ctl_q.active < PCNT_W'(NPART)))
            act = RSZ_GROW;
        else if (period_end && (target < ctl_q.active) && live_clear)
            act = RSZ_SHRINK;

        case (act)
            RSZ_GROW:   ctl_d.active = ctl_q.active + PCNT_W'(1);
            RSZ_SHRINK: ctl_d.active = target;
            default:    ctl_d.active = ctl_q.active;
        endcase

        if (act == RSZ_GROW || period_end) ctl_d.ovf = '0;
        else if (ovf_inc > OVF_W'(OT))     ctl_d.ovf = OVF_W'(OT + 1);
        else                               ctl_d.ovf = ovf_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.active <= PCNT_W'(NPART);
            ctl_q.ovf    <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active_o = ctl_q.active;

    rsz_part_dec #(.NPART(NPART), .PCNT_W(PCNT_W)) u_dec (
        .active_i(ctl_q.active), .part_en_o(part_en_o)
    );

    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active >= PCNT_W'(1)) && (ctl_q.active <= PCNT_W'(NPART)));

    p_grow_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active > $past(ctl_q.active)) |->
        (ctl_q.active == $past(ctl_q.active) + PCNT_W'(1)));

    p_shrink_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.active < $past(ctl_q.active)) |-> $past(period_end));

    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (ctl_q.ovf == '0));
endmodule

// File: tb/sim_rob_part_sizer.sv
`timescale 1ns/1ps
module sim_rob_part_sizer;
    localparam int NPART = 4;
    localparam int PD    = 8;
    localparam int SP    = 4;
    localparam int UP    = 16;
    localparam int OT    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] occ = '0;
    logic       stall = 1'b0;
    logic [4:0] head = '0;
    logic [4:0] tail = '0;
    logic [2:0] active;
    logic [3:0] part_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int    exp_act_q[$];
    string exp_req_q[$];
    string cur_req = "R5";

    int m_sp = 0, m_up = 0, m_acc = 0, m_ovf = 0, m_act = NPART;

    always #2 clk = ~clk;

    rob_part_sizer #(.NPART(NPART), .PART_DEPTH(PD), .SP(SP), .UP(UP), .OT(OT)) u0 (
        .clk(clk), .rst_n(rst_n), .occ_i(occ), .full_stall_i(stall),
        .head_i(head), .tail_i(tail), .active_o(active), .part_en_o(part_en)
    );

    function automatic int exp_en(int a);
        int v = 0;
        for (int p = 0; p < NPART; p++) if (p < a) v |= (1 << p);
        return v;
    endfunction

    task automatic check(string req, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(int o, bit s, int h, int t);
        bit samp, pend, grow, shrink, ok;
        int sum, tgt, inc;
        occ = 6'(o); stall = s; head = 5'(h); tail = 5'(t);
        samp = (m_sp == SP - 1);
        pend = (m_up == UP - 1);
        sum  = m_acc + o;
        tgt  = ((sum / (UP / SP)) + PD - 1) / PD;
        if (tgt == 0) tgt = 1;
        ok   = (o == 0) || (t > h && t <= tgt * PD);
        inc  = m_ovf + s;
        grow   = (inc > OT) && (m_act < NPART);
        shrink = pend && (tgt < m_act) && ok && !grow;
        if (grow) m_act++;
        else if (shrink) m_act = tgt;
        if (grow || pend) m_ovf = 0;
        else m_ovf = (inc > OT) ? OT + 1 : inc;
        if (pend) m_acc = 0;
        else if (samp) m_acc = sum;
        m_sp = (m_sp + 1) % SP;
        m_up = (m_up + 1) % UP;
        exp_act_q.push_back(m_act);
        exp_req_q.push_back(cur_req);
        @(negedge clk);
    endtask

    // one window: occ_s at sampling phases, occ_n elsewhere, stall per phase bit
    task automatic window(int occ_s, int occ_n, int h, int t, logic [15:0] smask);
        for (int i = 0; i < UP; i++)
            step((i % SP == SP - 1) ? occ_s : occ_n, smask[i], h, t);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_act_q.size() > 0) begin
                int e;
                string r;
                e = exp_act_q.pop_front();
                r = exp_req_q.pop_front();
                check(r, int'(active), e, "active count");
                check("R2", int'(part_en), exp_en(e), "enable mask");
            end
        end
    end

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(active), NPART, "reset active");
        check("R1", int'(part_en), exp_en(NPART), "reset enables");
        rst_n = 1'b1;
        // R5: high average keeps full allocation
        cur_req = "R5";  window(30, 30, 0, 30, 16'h0000);
        // R4: average 10 -> two partitions
        cur_req = "R4";  window(10, 10, 0, 10, 16'h0000);
        // R3: large values only between samples are ignored -> floor of one
        cur_req = "R3";  window(0, 31, 0, 0, 16'h0000);
        // R7: five stalls grow by one, five more grow again
        cur_req = "R7";  window(20, 20, 0, 20, 16'b0000_0111_1101_1111);
        // R8: four stalls at window end plus one at next start: no growth
        cur_req = "R8";  window(20, 20, 0, 20, 16'hF000);
        cur_req = "R8";  window(20, 20, 0, 20, 16'h0001);
        // R6: live entries in partition two block shrink
        cur_req = "R6";  window(5, 5, 20, 25, 16'h0000);
        // R6: wrapped live region blocks shrink
        cur_req = "R6";  window(7, 7, 28, 3, 16'h0000);
        // R6: live region inside partition zero allows shrink to one
        cur_req = "R6";  window(4, 4, 4, 8, 16'h0000);
        // R10: grow lands on window end together with a due shrink
        cur_req = "R10"; window(0, 0, 0, 0, 16'b0000_0000_0001_1111);
        cur_req = "R10"; window(0, 0, 0, 0, 16'b1111_1000_0001_1111);
        // R9: stalls at full allocation change nothing
        cur_req = "R9";  window(30, 30, 0, 30, 16'b0000_0111_1111_1111);
        cur_req = "R9";  window(30, 30, 0, 30, 16'hFFFF);
        step(30, 0, 0, 30);
        @(posedge clk); #2;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule